// File: doc/BRIEF.md
# UART Interrupt Identification Logic

This block chooses which interrupt source a 16550-style UART reports and drives its single interrupt request line. The inputs are the enable bits, the receive status (data ready, FIFO fill count, trigger level selection, character-timeout pending) and the modem-status change bits. The block also receives the transmit-holding-register empty level and strobes for register accesses. From these it builds the identification byte, and it raises the request line whenever some source is both active and enabled.

The block keeps three pieces of state of its own:
- the transmit-empty pending flag, which accesses to the data, enable and identification registers set and clear;
- the sticky overrun indication;
- the sticky break indication.

The overrun and break indications are set by strobes from the receiver and cleared by a read of the line status register. Parity and framing error levels pass straight through to the error outputs. The serial shifter, the FIFO storage and the baud generator sit outside the block and connect through plain status and strobe ports.

Top module: `uart_irq_ident`

## Requirements
- R1: When several sources are active, exactly one code is reported. The order from highest to lowest is: line status (0x6), character timeout (0xC), received data (0x4), transmit-holding empty (0x2), modem status (0x0). When nothing is active the low nibble is 0x1.
- R2: Bits 7:6 of `iir` are 11 while `fifo_en` is 1 and 00 while it is 0. Bits 5:4 are always 0.
- R3: The line status source needs `ier[2]` and at least one bit of `lsr_err` set. The `lsr_err` bits are: bit 0 overrun, bit 1 parity, bit 2 framing, bit 3 break.
- R4: Both the character-timeout source (`tmo_pend`) and the received-data source are masked by `ier[0]`.
- R5: The received-data source needs `rx_ready`, and also needs either `fifo_en` low or `rx_count` at or above the trigger level. The trigger level is chosen by `trig_sel`: 00 gives 1, 01 gives 4, 10 gives 8, 11 gives 14.
- R6: The modem status source needs `ier[3]` and any bit of `msr_delta` set.
- R7: The transmit-empty pending flag is set in the cycle after `thr_empty` rises, and it is reported when `ier[1]` is 1. A `thr_wr` strobe clears it, and a strobe in the same cycle as a rise wins over the rise.
- R8: An `iir_rd` strobe clears the pending flag if the code shown in that cycle is 0x2. A read that shows any other code leaves the flag alone.
- R9: When `ier[1]` differs from its value in the previous cycle, the pending flag becomes (`ier[1]` and `thr_empty`). This rule takes precedence over every other update.
- R10: Overrun and break are set by `ovr_set` and `brk_set` and cleared by `lsr_rd`. A set in the same cycle as a read wins over the read. Parity and framing follow `line_err_lvl` (bit 0 parity, bit 1 framing) and are not affected by `lsr_rd`.
- R11: `irq` is registered. It is high in the cycle after the reported code is not 0x1, and low in the cycle after the code is 0x1.
- R12: After reset `iir` reads 0x01 with all inputs low, `irq` is 0, and the pending, overrun and break flags are clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| fifo_en | input | 1 | FIFO mode enabled |
| ier | input | 4 | Enables: 0 receive data/timeout, 1 transmit empty, 2 line status, 3 modem |
| line_err_lvl | input | 2 | Parity (bit 0) and framing (bit 1) error levels |
| ovr_set | input | 1 | Overrun event strobe |
| brk_set | input | 1 | Break event strobe |
| lsr_rd | input | 1 | Line status register read strobe |
| lsr_err | output | 4 | Break, framing, parity, overrun (bits 3..0) |
| rx_ready | input | 1 | Receive data ready |
| rx_count | input | CNT_W | Receive FIFO fill count |
| trig_sel | input | 2 | Receive trigger level select |
| tmo_pend | input | 1 | Character timeout pending |
| thr_empty | input | 1 | Transmit holding register / FIFO empty |
| thr_wr | input | 1 | Transmit holding register write strobe |
| msr_delta | input | 4 | Modem status change bits |
| iir_rd | input | 1 | Identification register read strobe |
| iir | output | 8 | Identification byte |
| irq | output | 1 | Interrupt request |

## Verification
The hardest situation to reach is re-arming the transmit-empty source while the holding register stays empty. With `thr_empty` steady there is no rising edge to set the flag again. The bench therefore first masks the source by reading the identification byte while it shows 0x2. It then turns `ier[1]` off for one cycle and back on, and checks that 0x2 returns. It runs the same toggle with `thr_empty` low and checks that 0x2 does not return. A second hard case is a read that shows a higher-priority code while the flag is pending. The bench raises a parity error over a pending transmit-empty source, reads the byte, removes the error, and expects 0x2 to come back.

// File: rtl/uart_irq_ident.sv
module uart_irq_ident #(
  parameter int CNT_W   = 5,
  parameter int TRIG_L0 = 1,
  parameter int TRIG_L1 = 4,
  parameter int TRIG_L2 = 8,
  parameter int TRIG_L3 = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fifo_en,
  input  logic [3:0]       ier,
  input  logic [1:0]       line_err_lvl,
  input  logic             ovr_set,
  input  logic             brk_set,
  input  logic             lsr_rd,
  output logic [3:0]       lsr_err,
  input  logic             rx_ready,
  input  logic [CNT_W-1:0] rx_count,
  input  logic [1:0]       trig_sel,
  input  logic             tmo_pend,
  input  logic             thr_empty,
  input  logic             thr_wr,
  input  logic [3:0]       msr_delta,
  input  logic             iir_rd,
  output logic [7:0]       iir,
  output logic             irq
);

  localparam logic [3:0] ID_NONE = 4'h1;
  localparam logic [3:0] ID_LINE = 4'h6;
  localparam logic [3:0] ID_TMO  = 4'hC;
  localparam logic [3:0] ID_RXD  = 4'h4;
  localparam logic [3:0] ID_THR  = 4'h2;
  localparam logic [3:0] ID_MDM  = 4'h0;

  logic ovr_q, brk_q, pend_q, thr_empty_q, ier_thr_q, irq_q;
  logic [CNT_W-1:0] trig_lvl;
  logic [3:0] code;

  assign lsr_err = {brk_q, line_err_lvl[1], line_err_lvl[0], ovr_q};

  always_comb begin
    case (trig_sel)
      2'd0:    trig_lvl = CNT_W'(TRIG_L0);
      2'd1:    trig_lvl = CNT_W'(TRIG_L1);
      2'd2:    trig_lvl = CNT_W'(TRIG_L2);
      default: trig_lvl = CNT_W'(TRIG_L3);
    endcase
  end

  wire src_line = ier[2] & (|lsr_err);
  wire src_tmo  = ier[0] & tmo_pend;
  wire src_rxd  = ier[0] & rx_ready & (~fifo_en | (rx_count >= trig_lvl));
  wire src_thr  = ier[1] & pend_q;
  wire src_mdm  = ier[3] & (|msr_delta);

  always_comb begin
    if (src_line)     code = ID_LINE;
    else if (src_tmo) code = ID_TMO;
    else if (src_rxd) code = ID_RXD;
    else if (src_thr) code = ID_THR;
    else if (src_mdm) code = ID_MDM;
    else              code = ID_NONE;
  end

  assign iir = {{2{fifo_en}}, 2'b00, code};
  assign irq = irq_q;

  wire ier_thr_chg = ier[1] ^ ier_thr_q;
  wire thr_rise    = thr_empty & ~thr_empty_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q      <= 1'b0;
      thr_empty_q <= 1'b0;
      ier_thr_q   <= 1'b0;
      ovr_q       <= 1'b0;
      brk_q       <= 1'b0;
      irq_q       <= 1'b0;
    end else begin
      thr_empty_q <= thr_empty;
      ier_thr_q   <= ier[1];
      irq_q       <= (code != ID_NONE);
      if (ier_thr_chg)                     pend_q <= ier[1] & thr_empty;
      else if (thr_wr)                     pend_q <= 1'b0;
      else if (iir_rd && code == ID_THR)   pend_q <= 1'b0;
      else if (thr_rise)                   pend_q <= 1'b1;
      if (ovr_set)     ovr_q <= 1'b1;
      else if (lsr_rd) ovr_q <= 1'b0;
      if (brk_set)     brk_q <= 1'b1;
      else if (lsr_rd) brk_q <= 1'b0;
    end
  end

endmodule

module uart_irq_ident_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [3:0] ier,
  input logic [3:0] lsr_err,
  input logic       ovr_set,
  input logic       brk_set,
  input logic       lsr_rd,
  input logic       thr_wr,
  input logic [3:0] msr_delta,
  input logic [7:0] iir,
  input logic       irq
);

  p_irq_high_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (iir[3:0] != 4'h1) |=> irq);

  p_irq_low_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (iir[3:0] == 4'h1) |=> !irq);

  p_line_top_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ier[2] && (|lsr_err)) |-> (iir[3:0] == 4'h6));

  p_mdm_src_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (iir[3:0] == 4'h0) |-> (ier[3] && (|msr_delta)));

  p_lsr_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (lsr_rd && !ovr_set && !brk_set) |=> (!lsr_err[0] && !lsr_err[3]));

  p_thr_wr_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (thr_wr && $stable(ier[1])) |=> (iir[3:0] != 4'h2));

  p_hi_bits_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (iir[5:4] == 2'b00) && (iir[7] == iir[6]));

endmodule

bind uart_irq_ident uart_irq_ident_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ier(ier), .lsr_err(lsr_err),
  .ovr_set(ovr_set), .brk_set(brk_set), .lsr_rd(lsr_rd),
  .thr_wr(thr_wr), .msr_delta(msr_delta), .iir(iir), .irq(irq)
);

// File: tb/uart_irq_ident_tb.sv
module uart_irq_ident_tb;
  localparam int CLK_PERIOD = 10;
  localparam int CNT_W = 5;

  logic clk = 1'b0, rst_n = 1'b0;
  logic fifo_en = 0, ovr_set = 0, brk_set = 0, lsr_rd = 0, rx_ready = 0;
  logic tmo_pend = 0, thr_empty = 0, thr_wr = 0, iir_rd = 0;
  logic [3:0] ier = 0, msr_delta = 0, lsr_err;
  logic [1:0] line_err_lvl = 0, trig_sel = 0;
  logic [CNT_W-1:0] rx_count = 0;
  logic [7:0] iir;
  logic irq;
  int total = 0, bad = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  uart_irq_ident #(.CNT_W(CNT_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .ier(ier),
    .line_err_lvl(line_err_lvl), .ovr_set(ovr_set), .brk_set(brk_set),
    .lsr_rd(lsr_rd), .lsr_err(lsr_err), .rx_ready(rx_ready),
    .rx_count(rx_count), .trig_sel(trig_sel), .tmo_pend(tmo_pend),
    .thr_empty(thr_empty), .thr_wr(thr_wr), .msr_delta(msr_delta),
    .iir_rd(iir_rd), .iir(iir), .irq(irq)
  );

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset();
    check("R12 iir", iir, 8'h01);
    check("R12 irq", {7'd0, irq}, 8'h00);
    check("R12 lsr_err", {4'd0, lsr_err}, 8'h00);
  endtask

  task automatic t_fifo_bits();
    fifo_en = 1; #1;
    check("R2 fifo on", iir, 8'hC1);
    fifo_en = 0; #1;
    check("R2 fifo off", iir, 8'h01);
  endtask

  task automatic t_line();
    ier = 4'h4; line_err_lvl = 2'b01; #1;
    check("R3 parity", iir, 8'h06);
    ier = 4'h0; #1;
    check("R3 masked", iir, 8'h01);
    line_err_lvl = 2'b00; tick();
  endtask

  task automatic t_priority();
    ier = 4'hF; tick();
    line_err_lvl = 2'b10; tmo_pend = 1; rx_ready = 1; msr_delta = 4'h1;
    thr_empty = 1; tick();
    check("R1 line first", iir, 8'h06);
    line_err_lvl = 0; #1;
    check("R1 timeout next", iir, 8'h0C);
    tmo_pend = 0; #1;
    check("R1 data next", iir, 8'h04);
    rx_ready = 0; #1;
    check("R1 R7 thre next", iir, 8'h02);
    iir_rd = 1; tick(); iir_rd = 0; #1;
    check("R8 read clears, R6 modem", iir, 8'h00);
    msr_delta = 0; #1;
    check("R1 none", iir, 8'h01);
    ier = 4'h0; thr_empty = 0; tick(); tick();
  endtask

  task automatic t_rxtrig();
    ier = 4'h1; fifo_en = 1; rx_ready = 1; trig_sel = 2'b01; rx_count = 3; #1;
    check("R5 below 4", iir, 8'hC1);
    rx_count = 4; #1;
    check("R5 at 4", iir, 8'hC4);
    trig_sel = 2'b11; rx_count = 13; #1;
    check("R5 below 14", iir, 8'hC1);
    rx_count = 14; #1;
    check("R5 at 14", iir, 8'hC4);
    trig_sel = 2'b10; rx_count = 8; #1;
    check("R5 at 8", iir, 8'hC4);
    fifo_en = 0; rx_count = 0; #1;
    check("R5 no fifo", iir, 8'h04);
    ier = 4'h0; #1;
    check("R4 data masked", iir, 8'h01);
    rx_ready = 0; tmo_pend = 1; #1;
    check("R4 timeout masked", iir, 8'h01);
    ier = 4'h1; #1;
    check("R4 timeout on", iir, 8'h0C);
    tmo_pend = 0; ier = 0; trig_sel = 0; tick();
  endtask

  task automatic t_thr_write();
    ier = 4'h2; thr_empty = 0; tick(); tick();
    thr_empty = 1; tick();
    check("R7 rise sets", iir, 8'h02);
    thr_wr = 1; thr_empty = 0; tick(); thr_wr = 0;
    check("R7 write clears", iir, 8'h01);
    thr_empty = 1; thr_wr = 1; tick(); thr_wr = 0;
    check("R7 write beats rise", iir, 8'h01);
    thr_empty = 0; tick(); thr_empty = 1; tick();
    check("R7 rise again", iir, 8'h02);
  endtask

  task automatic t_read_other();
    ier = 4'h6; line_err_lvl = 2'b01; #1;
    check("R8 line over thre", iir, 8'h06);
    iir_rd = 1; tick(); iir_rd = 0;
    line_err_lvl = 0; #1;
    check("R8 other read keeps", iir, 8'h02);
    ier = 4'h2; tick();
  endtask

  task automatic t_ier_toggle();
    iir_rd = 1; tick(); iir_rd = 0;
    check("R8 cleared", iir, 8'h01);
    ier = 4'h0; tick(); ier = 4'h2; tick();
    check("R9 rearm", iir, 8'h02);
    thr_wr = 1; thr_empty = 0; tick(); thr_wr = 0;
    ier = 4'h0; tick(); ier = 4'h2; tick();
    check("R9 no rearm thre low", iir, 8'h01);
    ier = 0; tick();
  endtask

  task automatic t_lsr();
    ovr_set = 1; tick(); ovr_set = 0;
    check("R10 overrun", {4'd0, lsr_err}, 8'h01);
    brk_set = 1; tick(); brk_set = 0;
    check("R10 break", {4'd0, lsr_err}, 8'h09);
    line_err_lvl = 2'b11; lsr_rd = 1; tick(); lsr_rd = 0;
    check("R10 read clears", {4'd0, lsr_err}, 8'h06);
    line_err_lvl = 0; ovr_set = 1; lsr_rd = 1; tick(); ovr_set = 0; lsr_rd = 0;
    check("R10 set wins", {4'd0, lsr_err}, 8'h01);
    lsr_rd = 1; tick(); lsr_rd = 0;
    check("R10 cleared", {4'd0, lsr_err}, 8'h00);
  endtask

  task automatic t_irq();
    check("R11 idle", {7'd0, irq}, 8'h00);
    ier = 4'h8; msr_delta = 4'h4; #1;
    check("R11 not yet", {7'd0, irq}, 8'h00);
    tick();
    check("R11 raised", {7'd0, irq}, 8'h01);
    msr_delta = 0; #1;
    check("R11 held", {7'd0, irq}, 8'h01);
    tick();
    check("R11 dropped", {7'd0, irq}, 8'h00);
    ier = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_fifo_bits();
    t_line();
    t_priority();
    t_rxtrig();
    t_thr_write();
    t_read_other();
    t_ier_toggle();
    t_lsr();
    t_irq();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=hung expected=done");
      end
    join_any
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule